// File: doc/BRIEF.md
# Read-Cycle Four-Phase Handshake Sequencer

This block is a synchronous model of the control unit that steps a peripheral read through a four-phase handshake. On the bus side it receives a data-strobe request and answers with a bus acknowledge. On the device side it raises a device request, waits for the device acknowledge, and then opens a data-latch enable. Each clock edge, the block looks at its two inputs and its own output state, and it moves at most one of its outputs. The moves follow the fixed order of a read cycle.

Two phases of the cycle would show the same pattern on the five interface wires. These are the phase in which the device has acknowledged but data is not yet latched, and a phase on the return path. To tell them apart, a phase flag is raised once the strobe arrives and lowered once the strobe is withdrawn. A compile-time parameter can remove the flag. In that variant the conflict is avoided by making the device request fall before a new strobe is accepted, and every cycle is one edge shorter in each direction.

The block also watches the environment. If the strobe or the device acknowledge changes when the read ordering does not permit it, a protocol-error output is set and stays set until reset.

Top module: `read_handshake_ctrl`

## Requirements
- R1: While reset is asserted and on the first edge after it, devReq, latchEn, busAck, phaseFlag and protoErr are all 0.
- R2: With STATE_BIT=1, when all outputs are low and dsReq is sampled 1 with devAck 0, phaseFlag rises on that edge and devReq rises on the next edge.
- R3: While devReq is high and the data latch is closed, sampling devAck 1 raises latchEn on that edge, and busAck rises on the following edge.
- R4: With busAck high, sampling dsReq 0 starts the return sequence, one step per edge: phaseFlag falls (STATE_BIT=1 only), then latchEn falls, then devReq falls, then busAck falls.
- R5: At most one of devReq, latchEn, busAck and phaseFlag changes on any edge.
- R6: With all outputs low, the sequencer stays idle while devAck is high, even when dsReq is high.
- R7: protoErr is set when dsReq rises unless devReq, latchEn, busAck, phaseFlag and devAck are all low.
- R8: protoErr is set when dsReq falls while busAck is low.
- R9: protoErr is set when devAck rises unless devReq is high and latchEn and busAck are low, and also when devAck falls while devReq is high.
- R10: Once set, protoErr stays 1 until reset.
- R11: With STATE_BIT=0, phaseFlag stays 0. devReq rises on the edge that first samples dsReq 1, and latchEn falls on the edge that first samples dsReq 0.
- R12: A complete legal cycle leaves protoErr at 0. This includes devAck falling after devReq has fallen and a new strobe following once busAck is low. A second cycle then starts exactly as R2 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| dsReq | input | 1 | Data-strobe request from the bus side |
| devAck | input | 1 | Acknowledge from the device |
| devReq | output | 1 | Request to the device |
| latchEn | output | 1 | Data-latch enable |
| busAck | output | 1 | Acknowledge to the bus side |
| phaseFlag | output | 1 | Phase-separating state bit (0 when STATE_BIT=0) |
| protoErr | output | 1 | Sticky protocol-ordering error |

## Verification
If the internal phase is wrong, the error shows at the ports on the next edge. An output moves out of turn, or two outputs move together, or the expected output fails to move when its triggering input arrives. The worst case is confusing the latched-acknowledge phase with the return phase. That would make latchEn fall or rise one edge after the input that should have caused the opposite move. The bench therefore compares every output on every edge of complete cycles in both variants. It also injects out-of-order strobe and acknowledge edges in several phases, so that a wrongly decoded phase appears as a missing or spurious protoErr.

// File: rtl/read_handshake_pkg.sv
package read_handshake_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FLAGGED,
    PH_REQUESTED,
    PH_LATCHED,
    PH_ACKED,
    PH_UNFLAGGED,
    PH_UNLATCHED,
    PH_RELEASED
  } phase_e;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic setReq;
    logic clrReq;
    logic setLatch;
    logic clrLatch;
    logic setAck;
    logic clrAck;
  } strobe_t;

  localparam strobe_t NO_STROBE = '0;

endpackage

// File: rtl/read_handshake_seq.sv
module read_handshake_seq
  import read_handshake_pkg::*;
#(
  parameter bit STATE_BIT = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    dsReq,
  input  logic    devAck,
  output strobe_t strobes
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobes   = NO_STROBE;
    unique case (phase)
      PH_IDLE: begin
        if (dsReq && !devAck) begin
          if (STATE_BIT) begin
            strobes.setFlag = 1'b1;
            phaseNext       = PH_FLAGGED;
          end else begin
            strobes.setReq  = 1'b1;
            phaseNext       = PH_REQUESTED;
          end
        end
      end
      PH_FLAGGED: begin
        strobes.setReq = 1'b1;
        phaseNext      = PH_REQUESTED;
      end
      PH_REQUESTED: begin
        if (devAck) begin
          strobes.setLatch = 1'b1;
          phaseNext        = PH_LATCHED;
        end
      end
      PH_LATCHED: begin
        strobes.setAck = 1'b1;
        phaseNext      = PH_ACKED;
      end
      PH_ACKED: begin
        if (!dsReq) begin
          if (STATE_BIT) begin
            strobes.clrFlag  = 1'b1;
            phaseNext        = PH_UNFLAGGED;
          end else begin
            strobes.clrLatch = 1'b1;
            phaseNext        = PH_UNLATCHED;
          end
        end
      end
      PH_UNFLAGGED: begin
        strobes.clrLatch = 1'b1;
        phaseNext        = PH_UNLATCHED;
      end
      PH_UNLATCHED: begin
        strobes.clrReq = 1'b1;
        phaseNext      = PH_RELEASED;
      end
      PH_RELEASED: begin
        strobes.clrAck = 1'b1;
        phaseNext      = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/read_handshake_outs.sv
module read_handshake_outs
  import read_handshake_pkg::*;
#(
  parameter bit STATE_BIT = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  output logic    devReq,
  output logic    latchEn,
  output logic    busAck,
  output logic    phaseFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devReq  <= 1'b0;
      latchEn <= 1'b0;
      busAck  <= 1'b0;
    end else begin
      if (strobes.setReq)        devReq  <= 1'b1;
      else if (strobes.clrReq)   devReq  <= 1'b0;
      if (strobes.setLatch)      latchEn <= 1'b1;
      else if (strobes.clrLatch) latchEn <= 1'b0;
      if (strobes.setAck)        busAck  <= 1'b1;
      else if (strobes.clrAck)   busAck  <= 1'b0;
    end
  end

  generate
    if (STATE_BIT) begin : g_flag
      logic flagQ;
      always_ff @(posedge clk) begin
        if (!rstN)                flagQ <= 1'b0;
        else if (strobes.setFlag) flagQ <= 1'b1;
        else if (strobes.clrFlag) flagQ <= 1'b0;
      end
      assign phaseFlag = flagQ;
    end else begin : g_noflag
      assign phaseFlag = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/read_handshake_guard.sv
module read_handshake_guard (
  input  logic clk,
  input  logic rstN,
  input  logic dsReq,
  input  logic devAck,
  input  logic devReq,
  input  logic latchEn,
  input  logic busAck,
  input  logic phaseFlag,
  output logic protoErr
);

  logic dsPrev, ackPrev;
  logic dsRise, dsFall, ackRise, ackFall;
  logic allQuiet, badEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dsPrev  <= 1'b0;
      ackPrev <= 1'b0;
    end else begin
      dsPrev  <= dsReq;
      ackPrev <= devAck;
    end
  end

  assign dsRise   = dsReq & ~dsPrev;
  assign dsFall   = ~dsReq & dsPrev;
  assign ackRise  = devAck & ~ackPrev;
  assign ackFall  = ~devAck & ackPrev;
  assign allQuiet = ~devReq & ~latchEn & ~busAck & ~phaseFlag;

  always_comb begin
    badEdge = 1'b0;
    if (dsRise && !(allQuiet && !devAck))              badEdge = 1'b1;
    if (dsFall && !busAck)                             badEdge = 1'b1;
    if (ackRise && !(devReq && !latchEn && !busAck))   badEdge = 1'b1;
    if (ackFall && devReq)                             badEdge = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        protoErr <= 1'b0;
    else if (badEdge) protoErr <= 1'b1;
  end

endmodule

// File: rtl/read_handshake_ctrl.sv
module read_handshake_ctrl
  import read_handshake_pkg::*;
#(
  parameter bit STATE_BIT = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic dsReq,
  input  logic devAck,
  output logic devReq,
  output logic latchEn,
  output logic busAck,
  output logic phaseFlag,
  output logic protoErr
);

  strobe_t strobes;

  read_handshake_seq #(.STATE_BIT(STATE_BIT)) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .dsReq   (dsReq),
    .devAck  (devAck),
    .strobes (strobes)
  );

  read_handshake_outs #(.STATE_BIT(STATE_BIT)) u_outs (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .devReq    (devReq),
    .latchEn   (latchEn),
    .busAck    (busAck),
    .phaseFlag (phaseFlag)
  );

  read_handshake_guard u_guard (
    .clk       (clk),
    .rstN      (rstN),
    .dsReq     (dsReq),
    .devAck    (devAck),
    .devReq    (devReq),
    .latchEn   (latchEn),
    .busAck    (busAck),
    .phaseFlag (phaseFlag),
    .protoErr  (protoErr)
  );

endmodule

// File: rtl/read_handshake_chk.sv
module read_handshake_chk #(
  parameter bit STATE_BIT = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic dsReq,
  input logic devAck,
  input logic devReq,
  input logic latchEn,
  input logic busAck,
  input logic phaseFlag,
  input logic protoErr
);

  // R5
  single_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({devReq, latchEn, busAck, phaseFlag} ^
               $past({devReq, latchEn, busAck, phaseFlag})) <= 1);

  // R3
  latch_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchEn) |-> devReq && $past(devAck));

  // R3
  ack_after_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> latchEn && devReq);

  // R6
  req_needs_quiet_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devReq) |-> !$past(devAck));

  // R4
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phaseFlag) |-> latchEn && busAck && !$past(dsReq));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R11
  no_flag_variant_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(STATE_BIT == 1'b0 && phaseFlag));

endmodule

bind read_handshake_ctrl read_handshake_chk #(.STATE_BIT(STATE_BIT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dsReq     (dsReq),
  .devAck    (devAck),
  .devReq    (devReq),
  .latchEn   (latchEn),
  .busAck    (busAck),
  .phaseFlag (phaseFlag),
  .protoErr  (protoErr)
);

// File: tb/tb_read_handshake_ctrl.sv
module tb_read_handshake_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {dsReq, devAck, phaseFlag, devReq, latchEn, busAck, protoErr}
  localparam logic [6:0] VEC [0:NVEC-1] = '{
    7'b00_00000,  // idle
    7'b10_10000,  // R2 flag up
    7'b10_11000,  // R2 request up
    7'b10_11000,  // waiting for device
    7'b11_11100,  // R3 latch open
    7'b11_11110,  // R3 bus ack
    7'b11_11110,  // holding
    7'b01_01110,  // R4 flag down
    7'b01_01010,  // R4 latch closed
    7'b01_00010,  // R4 request down
    7'b01_00000,  // R4 bus ack down
    7'b00_00000,  // R12 device ack drops, no error
    7'b10_10000,  // R12 new cycle flag
    7'b10_11000   // R12 new cycle request
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dsReq = 1'b0, devAck = 1'b0;
  logic dsReqR = 1'b0, devAckR = 1'b0;
  logic devReq, latchEn, busAck, phaseFlag, protoErr;
  logic devReqR, latchEnR, busAckR, phaseFlagR, protoErrR;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  read_handshake_ctrl #(.STATE_BIT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .dsReq(dsReq), .devAck(devAck),
    .devReq(devReq), .latchEn(latchEn), .busAck(busAck),
    .phaseFlag(phaseFlag), .protoErr(protoErr)
  );

  read_handshake_ctrl #(.STATE_BIT(1'b0)) dutRed (
    .clk(clk), .rstN(rstN), .dsReq(dsReqR), .devAck(devAckR),
    .devReq(devReqR), .latchEn(latchEnR), .busAck(busAckR),
    .phaseFlag(phaseFlagR), .protoErr(protoErrR)
  );

  task automatic expect5(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {flag,req,latch,ack,err} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic ds, input logic ack);
    @(negedge clk);
    dsReq  = ds;
    devAck = ack;
    @(posedge clk);
    #1;
  endtask

  task automatic stepR(input logic ds, input logic ack);
    @(negedge clk);
    dsReqR  = ds;
    devAckR = ack;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    dsReq = 1'b0; devAck = 1'b0; dsReqR = 1'b0; devAckR = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [4:0] obs();
    return {phaseFlag, devReq, latchEn, busAck, protoErr};
  endfunction

  function automatic logic [4:0] obsR();
    return {phaseFlagR, devReqR, latchEnR, busAckR, protoErrR};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(posedge clk);
    #1;
    expect5("R1 during reset", obs(), 5'b00000);
    doReset();
    @(posedge clk);
    #1;
    expect5("R1 first edge after reset", obs(), 5'b00000);
    expect5("R1 variant after reset", obsR(), 5'b00000);

    // Full legal cycles: R2 R3 R4 R5 R12
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][6], VEC[i][5]);
      expect5($sformatf("R2/R3/R4/R12 vector %0d", i), obs(), VEC[i][4:0]);
    end

    // R8: strobe withdrawn while bus ack low
    step(1'b0, 1'b0);
    expect5("R8 early strobe drop", {protoErr}, 1'b1);
    // R10: sticky
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    expect5("R10 error held", {protoErr}, 1'b1);

    // R9: device ack rises with no request
    doReset();
    step(1'b0, 1'b1);
    expect5("R9 unsolicited ack", obs(), 5'b00001);
    // R6: idle holds while device ack high
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    expect5("R6 idle held with ack high", obs(), 5'b00001);

    // R9: device ack falls while request high
    doReset();
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    expect5("R9 legal ack rise", obs(), 5'b11100);
    step(1'b1, 1'b0);
    expect5("R9 ack fall with request high", {protoErr}, 1'b1);

    // R7: strobe re-rises while latch still open
    doReset();
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    expect5("R7 setup", obs(), 5'b11110);
    step(1'b0, 1'b1);
    expect5("R7 legal drop", obs(), 5'b01110);
    step(1'b1, 1'b1);
    expect5("R7 strobe rise mid-return", {protoErr}, 1'b1);

    // R11: variant without phase flag
    doReset();
    stepR(1'b1, 1'b0);
    expect5("R11 request on first edge", obsR(), 5'b01000);
    stepR(1'b1, 1'b1);
    expect5("R11 latch", obsR(), 5'b01100);
    stepR(1'b1, 1'b1);
    expect5("R11 bus ack", obsR(), 5'b01110);
    stepR(1'b0, 1'b1);
    expect5("R11 latch closes on first edge", obsR(), 5'b01010);
    stepR(1'b0, 1'b1);
    expect5("R11 request down", obsR(), 5'b00010);
    stepR(1'b0, 1'b0);
    expect5("R11 bus ack down, R12 no error", obsR(), 5'b00000);
    stepR(1'b1, 1'b0);
    expect5("R11 second cycle", obsR(), 5'b01000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule